// File: doc/BRIEF.md
# Receive Error Report Ring Writer

This block turns receive-side error events into two-word report messages and stores them in a 32-slot circular area of host memory. Each event carries the frame's 48-bit source MAC address, the receiving port, a 5-bit device number, and two error-kind flags: a bad CRC and an over-length frame. An event with neither flag set produces no message.

The block splits the MAC address across two 32-bit words and packs the flags, port and device number around it. It presents the two words as write requests on a valid/ready memory-write port. The slot address is built from a host-programmed base register and a 5-bit slot index. Events that arrive while a message is being written wait in a small FIFO.

After the second word of a message is accepted, the block advances the slot index and sets an interrupt cause bit. The host can either take the maskable interrupt or poll the area. Because the cause bit is set only after the second word is accepted, a reported message is always complete in memory.

Top module: `rx_err_ring_writer`

## Requirements
- R1: An event is accepted when `ev_valid` is high and at least one of `ev_fcs` or `ev_long` is high. An event with both flags low is ignored and produces no write.
- R2: The first word of a message has the following layout:
  - bits [31:3] hold MAC bits [47:19];
  - bit 2 is always 1;
  - bit 1 is the CRC flag;
  - bit 0 is the over-length flag.
- R3: The second word of a message has the following layout:
  - bits [31:25] are zero;
  - bit 24 is the port;
  - bits [23:19] are the device number, with bit 23 as its MSB;
  - bits [18:0] hold MAC bits [18:0].
- R4: Both words of a message use the same slot address, {base[31:8], slot[4:0], 3'b000}. The first word is written at that address and the second at that address plus 4 (address bit 2 set). The slot index advances only after the second word is accepted, and wraps from 31 to 0.
- R5: The base register keeps only bits [31:8] of a write. `base_q` reads bits [7:0] as zero and resets to 0. A base write sets the slot index to 0.
- R6: The first word is always written before the second. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R7: Accepted events wait in a 4-deep FIFO and are written in arrival order. An event accepted while the FIFO holds 4 events is dropped, and `ovf` is set and stays set until reset.
- R8: `irq_cause` goes high in the cycle after the second word is accepted. A pulse on `irq_clr` clears it. If a completion and a clear fall in the same cycle, the completion wins.
- R9: `irq` equals `irq_cause` AND `irq_mask`. `irq_mask` is loaded from `irq_mask_wdata` when `irq_mask_we` is high.
- R10: After reset, `wr_valid`, `irq_cause`, `irq_mask`, `irq`, `ovf` and `base_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Error event strobe |
| ev_mac | input | 48 | Source MAC address of the errored frame |
| ev_port | input | 1 | Receiving port |
| ev_dev | input | 5 | Device number |
| ev_fcs | input | 1 | CRC error flag |
| ev_long | input | 1 | Over-length error flag |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 32 | Base register write value |
| base_q | output | 32 | Base register value, bits [7:0] zero |
| irq_mask_we | input | 1 | Mask write strobe |
| irq_mask_wdata | input | 1 | Mask write value |
| irq_clr | input | 1 | Write-one-to-clear pulse for the cause bit |
| irq_cause | output | 1 | Message-written cause bit |
| irq_mask | output | 1 | Interrupt mask bit |
| irq | output | 1 | Interrupt output |
| ovf | output | 1 | Sticky event-drop flag |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write request accepted |

## Verification
The bench builds the block with its default FIFO depth of 4 and ring size of 32. With only 32 slots, a 40-message sweep runs the slot index through a full wrap and back. The sweep varies the flag combinations, ports and device numbers, and uses a stalling ready pattern. A depth of 4 lets a short burst fill the FIFO exactly and expose the drop and sticky-flag behaviour.

// File: rtl/rx_err_ring_writer.sv
module rx_err_ring_writer #(
  parameter int FIFO_DEPTH   = 4,
  parameter int RING_ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  logic [47:0] ev_mac,
  input  logic        ev_port,
  input  logic [4:0]  ev_dev,
  input  logic        ev_fcs,
  input  logic        ev_long,
  input  logic        base_we,
  input  logic [31:0] base_wdata,
  output logic [31:0] base_q,
  input  logic        irq_mask_we,
  input  logic        irq_mask_wdata,
  input  logic        irq_clr,
  output logic        irq_cause,
  output logic        irq_mask,
  output logic        irq,
  output logic        ovf,
  output logic        wr_valid,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  input  logic        wr_ready
);
  localparam int EW    = 56;
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int IDX_W = 5;

  typedef enum logic [1:0] {S_IDLE, S_W0, S_W1} st_t;

  st_t              st;
  logic [EW-1:0]    fifo_mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic [23:0]      base_r;
  logic [IDX_W-1:0] idx;
  logic [28:0]      ent_addr;
  logic [EW-1:0]    msg;

  wire push    = ev_valid & (ev_fcs | ev_long);
  wire full    = (cnt == CNT_W'(FIFO_DEPTH));
  wire push_ok = push & ~full;
  wire pop     = (st == S_IDLE) & (cnt != '0);
  wire done    = (st == S_W1) & wr_ready;

  wire [47:0] m_mac  = msg[55:8];
  wire        m_port = msg[7];
  wire [4:0]  m_dev  = msg[6:2];
  wire        m_fcs  = msg[1];
  wire        m_long = msg[0];

  assign base_q   = {base_r, 8'h00};
  assign wr_valid = (st != S_IDLE);
  assign wr_addr  = {ent_addr, st == S_W1, 2'b00};
  assign wr_data  = (st == S_W1) ? {7'd0, m_port, m_dev, m_mac[18:0]}
                                 : {m_mac[47:19], 1'b1, m_fcs, m_long};
  assign irq      = irq_cause & irq_mask;

  always_ff @(posedge clk) begin
    if (push_ok) fifo_mem[wp] <= {ev_mac, ev_port, ev_dev, ev_fcs, ev_long};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push_ok) wp <= (wp == PTR_W'(FIFO_DEPTH - 1)) ? '0 : PTR_W'(wp + 1'b1);
      if (pop)     rp <= (rp == PTR_W'(FIFO_DEPTH - 1)) ? '0 : PTR_W'(rp + 1'b1);
      cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop);
      if (push & full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      msg      <= '0;
      ent_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (pop) begin
          msg      <= fifo_mem[rp];
          ent_addr <= {base_r, idx};
          st       <= S_W0;
        end
        S_W0:    if (wr_ready) st <= S_W1;
        S_W1:    if (wr_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_r    <= '0;
      idx       <= '0;
      irq_cause <= 1'b0;
      irq_mask  <= 1'b0;
    end else begin
      if (base_we) base_r <= base_wdata[31:8];
      if (base_we) idx <= '0;
      else if (done) idx <= (idx == IDX_W'(RING_ENTRIES - 1)) ? '0 : IDX_W'(idx + 1'b1);
      if (done) irq_cause <= 1'b1;
      else if (irq_clr) irq_cause <= 1'b0;
      if (irq_mask_we) irq_mask <= irq_mask_wdata;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_addr[2]) |=>
      (wr_valid && wr_addr[2] && wr_addr[7:3] == $past(wr_addr[7:3])));

  assert_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr[2]) |=> irq_cause);

  assert_sticky_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && cnt == '0 && !(ev_valid && (ev_fcs || ev_long))) |=> !wr_valid);
endmodule

// File: tb/rx_err_ring_writer_tb.sv
`timescale 1ns/100ps
module rx_err_ring_writer_tb;
  logic        clk = 0, rst_n = 0;
  logic        ev_valid = 0, ev_port = 0, ev_fcs = 0, ev_long = 0;
  logic [47:0] ev_mac = '0;
  logic [4:0]  ev_dev = '0;
  logic        base_we = 0, irq_mask_we = 0, irq_mask_wdata = 0, irq_clr = 0;
  logic [31:0] base_wdata = '0, base_q, wr_addr, wr_data;
  logic        irq_cause, irq_mask, irq, ovf, wr_valid, wr_ready;

  always #2.5 clk = ~clk;

  rx_err_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_mac(ev_mac), .ev_port(ev_port),
    .ev_dev(ev_dev), .ev_fcs(ev_fcs), .ev_long(ev_long), .base_we(base_we),
    .base_wdata(base_wdata), .base_q(base_q), .irq_mask_we(irq_mask_we),
    .irq_mask_wdata(irq_mask_wdata), .irq_clr(irq_clr), .irq_cause(irq_cause),
    .irq_mask(irq_mask), .irq(irq), .ovf(ovf), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready));

  int checks = 0, failures = 0, cycles = 0;
  int n_push = 0, n_done = 0, n_writes = 0;
  int rdy_mode = 0;
  logic [47:0] q_mac [64];
  logic        q_port [64];
  logic [4:0]  q_dev [64];
  logic [1:0]  q_fl [64];
  logic [31:0] exp_base = '0;
  int          exp_slot = 0, wphase = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: wr_ready = 0;
      1: wr_ready = 1;
      default: wr_ready = (cycles % 3) != 0;
    endcase
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      logic [31:0] ea, ed;
      int h;
      h = n_done % 64;
      n_writes++;
      chk(n_done < n_push, "R1 unexpected write", wr_addr, 32'h0);
      ea = {exp_base[31:8], 5'(exp_slot), wphase[0], 2'b00};
      chk(wr_addr == ea, "R4 address", wr_addr, ea);
      if (wphase == 0) begin
        ed = {q_mac[h][47:19], 1'b1, q_fl[h]};
        chk(wr_data == ed, "R2 word0", wr_data, ed);
        wphase = 1;
      end else begin
        ed = {7'd0, q_port[h], q_dev[h], q_mac[h][18:0]};
        chk(wr_data == ed, "R3 word1", wr_data, ed);
        wphase = 0;
        exp_slot = (exp_slot + 1) % 32;
        n_done++;
      end
    end
  end

  task automatic send(input logic [47:0] mac, input logic p, input logic [4:0] d,
                      input logic [1:0] fl, input bit expect_kept);
    ev_valid = 1; ev_mac = mac; ev_port = p; ev_dev = d; {ev_fcs, ev_long} = fl;
    if (expect_kept) begin
      q_mac[n_push % 64] = mac; q_port[n_push % 64] = p;
      q_dev[n_push % 64] = d;   q_fl[n_push % 64] = fl;
      n_push++;
    end
    @(posedge clk); #1;
    ev_valid = 0;
  endtask

  task automatic drain;
    while (n_done < n_push) begin @(posedge clk); #1; end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!wr_valid && !irq_cause && !irq_mask && !irq && !ovf, "R10 reset flags",
        {wr_valid, irq_cause, irq_mask, irq, ovf}, 0);
    chk(base_q == 0, "R10 reset base", base_q, 0);
    @(posedge clk); #1;

    base_we = 1; base_wdata = 32'hA5C3_77FF;
    @(posedge clk); #1 base_we = 0;
    exp_base = 32'hA5C3_7700; exp_slot = 0;
    @(negedge clk);
    chk(base_q == 32'hA5C3_7700, "R5 base low bits zero", base_q, 32'hA5C3_7700);
    @(posedge clk); #1;

    send(48'h1234_5678_9ABC, 1, 5'd1, 2'b00, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!wr_valid, "R1 flagless event ignored", wr_valid, 0);
    @(posedge clk); #1;

    rdy_mode = 0;
    send(48'hAAAA_0000_0001, 0, 5'd3, 2'b10, 1);
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) send(48'hBBBB_0000_0000 + 48'(i), 1'(i), 5'(i + 7), 2'(i % 3 + 1), 1);
    @(negedge clk);
    chk(!ovf, "R7 no drop at depth 4", ovf, 0);
    chk(wr_valid && wr_addr[2] == 0, "R6 word0 first under stall", wr_addr, {exp_base[31:8], 8'h00});
    @(posedge clk); #1;
    send(48'hDEAD_DEAD_DEAD, 0, 5'd31, 2'b11, 0);
    @(negedge clk);
    chk(ovf, "R7 overflow flag set", ovf, 1);
    chk(!irq_cause, "R8 no cause before completion", irq_cause, 0);
    @(posedge clk); #1;
    rdy_mode = 1;
    drain();
    @(negedge clk);
    chk(ovf, "R7 overflow sticky", ovf, 1);
    chk(n_writes == 10, "R7 dropped event not written", n_writes, 10);
    chk(irq_cause && !irq, "R9 masked irq low", {irq_cause, irq}, 2'b10);
    @(posedge clk); #1;
    irq_mask_we = 1; irq_mask_wdata = 1;
    @(posedge clk); #1 irq_mask_we = 0;
    @(negedge clk);
    chk(irq, "R9 unmasked irq high", irq, 1);
    @(posedge clk); #1 irq_clr = 1;
    @(posedge clk); #1 irq_clr = 0;
    @(negedge clk);
    chk(!irq_cause && !irq, "R8 cause cleared", {irq_cause, irq}, 0);
    @(posedge clk); #1;

    rdy_mode = 2;
    for (int i = 0; i < 40; i++) begin
      while (n_push - n_done > 3) begin @(posedge clk); #1; end
      send({16'(i * 977), 32'(i * 32'h0101_0F0F)} ^ 48'hF0F0_0000_0000, 1'(i), 5'(i * 7),
           2'(i % 3 + 1), 1);
      if (i % 5 == 0) send(48'(i), 0, 5'd0, 2'b00, 0);
    end
    drain();
    @(negedge clk);
    chk(n_done == 45 && n_writes == 90, "R4 sweep with wrap complete", n_writes, 90);
    chk(irq_cause, "R8 cause set after sweep", irq_cause, 1);
    @(posedge clk); #1;

    base_we = 1; base_wdata = 32'h0000_4000;
    @(posedge clk); #1 base_we = 0;
    exp_base = 32'h0000_4000; exp_slot = 0;
    send(48'hFFFF_FFFF_FFFF, 1, 5'd31, 2'b11, 1);
    drain();
    @(negedge clk);
    chk(n_writes == 92, "R5 base write restarts slot 0", n_writes, 92);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule